// File: doc/BRIEF.md
# Masked Power-Good Window Monitor

This block decides whether a regulated rail is healthy. Each cycle it compares a digitized sample of the output voltage (`meas_code`) against a window placed around the target-voltage code (`target_code`) and drives a registered power-good flag (`pg_ok`). Both codes are unsigned, with 12.5 mV per LSB. The window reaches 24 LSB (300 mV) below the target and 16 LSB (200 mV) above it. For targets below 24 LSB the lower bound is dropped, so only the upper limit applies.

Some system transitions would otherwise raise false alarms. These are a change of target code and a deep-sleep entry or exit, which is signalled by a one-cycle `sleep_evt` strobe. Each of them starts a mask of `MASK_CYCLES` clock cycles, and the flag is frozen while the mask runs. A further event during the mask reloads the timer. When a mask was started by a sleep event and the output sags more than 16 LSB below the target, the mask stretches: it is held until the sag clears, and one full mask period follows. The flag stays low until the power-up sequencer raises `seq_en`.

The controller has four states:
- **OFF**: the flag is held low.
- **RUN**: the flag tracks the window live.
- **MASK**: the timer counts down.
- **SAG**: the mask is extended because of a sag.

The transitions are:
- **OFF→RUN** when `seq_en` is high.
- **RUN→MASK** on a restart event.
- **MASK→MASK** (reload) on a further restart.
- **MASK→SAG** on a sag during a sleep-started mask.
- **MASK→RUN** when the timer expires.
- **SAG→MASK** (reload) when the sag clears.
- **any→OFF** when `seq_en` is low.

Top module: `pgw_monitor`

## Requirements
- R1: While running with no mask, `pg_ok` is 1 exactly when target−24 ≤ meas ≤ target+16 (codes in LSB). It reflects the sample one clock edge after that sample is presented.
- R2: When target < 24, there is no lower bound: `pg_ok` is 1 exactly when meas ≤ target+16.
- R3: `pg_ok` is 0 in reset, and 0 after any edge at which `seq_en` is low. After `seq_en` rises, the flag follows the window from the second edge on.
- R4: An edge that sees `target_code` differ from its value at the previous edge freezes `pg_ok` for that edge plus `MASK_CYCLES` further edges. The next edge updates the flag live.
- R5: A one-cycle `sleep_evt` pulse freezes `pg_ok` with the same timing as R4.
- R6: A target change or sleep event during a running mask reloads the full mask period, measured from that event.
- R7: In a mask started by `sleep_evt`, while meas < target−16 the flag stays frozen for as long as the sag lasts. From the edge that sees the sag cleared, the R4 timing applies again.
- R8: A mask started only by target changes is not extended by a sag.
- R9: The upper bound target+16 is computed without wrap, so near the top code every sample up to the maximum code is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_en | input | 1 | Power-up sequencer permits the flag to rise |
| sleep_evt | input | 1 | One-cycle strobe on deep-sleep entry or exit |
| target_code | input | CODE_W | Target voltage code, 12.5 mV/LSB |
| meas_code | input | CODE_W | Measured output voltage code, 12.5 mV/LSB |
| pg_ok | output | 1 | Registered power-good flag |

## Verification
The bench sweeps every measured code against targets on both sides of the 24-LSB threshold and near the top code. An off-by-one bound, a lower check left on for low targets, or a wrapped upper limit would each flip the flag at a known code.

Freeze lengths are counted edge by edge after target changes, sleep pulses and a mid-mask restart. A timer that fails to reload, or a mask one cycle short or long, drops or keeps the flag at the wrong edge.

A long sleep sag must keep the flag frozen and then still give a full period. The same sag after a plain target change must not extend the mask, which catches an extension that is granted on every event.

// File: rtl/pgw_pkg.sv
package pgw_pkg;

    typedef enum logic [1:0] {
        PGW_OFF  = 2'd0,
        PGW_RUN  = 2'd1,
        PGW_MASK = 2'd2,
        PGW_SAG  = 2'd3
    } pgw_state_e;

endpackage

// File: rtl/pgw_window.sv
module pgw_window #(
    parameter int CODE_W     = 8,
    parameter int LO_MARGIN  = 24,
    parameter int HI_MARGIN  = 16,
    parameter int SAG_MARGIN = 16
) (
    input  logic [CODE_W-1:0] target,
    input  logic [CODE_W-1:0] meas,
    output logic              in_win,
    output logic              sag
);
    localparam int EXT_W = CODE_W + 1;

    logic [EXT_W-1:0] t_ext;
    logic [EXT_W-1:0] m_ext;
    logic [EXT_W-1:0] hi_lim;
    logic             lo_active;
    logic             lo_ok;
    logic             hi_ok;

    always_comb begin
        t_ext     = {1'b0, target};
        m_ext     = {1'b0, meas};
        // one extra bit keeps target+margin from wrapping
        hi_lim    = t_ext + EXT_W'(HI_MARGIN);
        hi_ok     = (m_ext <= hi_lim);
        lo_active = (t_ext >= EXT_W'(LO_MARGIN));
        lo_ok     = !lo_active || (m_ext >= (t_ext - EXT_W'(LO_MARGIN)));
        in_win    = hi_ok && lo_ok;
        sag       = (t_ext >= EXT_W'(SAG_MARGIN)) &&
                    (m_ext < (t_ext - EXT_W'(SAG_MARGIN)));
    end

endmodule

// File: rtl/pgw_change_det.sv
module pgw_change_det #(
    parameter int CODE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] target,
    input  logic              sleep_evt,
    output logic              restart
);
    logic [CODE_W-1:0] target_q;
    logic              target_chg;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            target_q <= '0;
        end else begin
            target_q <= target;
        end
    end

    always_comb begin
        target_chg = (target != target_q);
        restart    = target_chg || sleep_evt;
    end

endmodule

// File: rtl/pgw_mask_timer.sv
module pgw_mask_timer #(
    parameter int MASK_CYCLES = 16250,
    parameter int CNT_W       = $clog2(MASK_CYCLES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    output logic             done,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(MASK_CYCLES - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (load) begin
            cnt <= RELOAD;
        end else if (step && (cnt != '0)) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign done = (cnt == '0);

endmodule

// File: rtl/pgw_monitor.sv
module pgw_monitor
    import pgw_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int LO_MARGIN   = 24,
    parameter int HI_MARGIN   = 16,
    parameter int SAG_MARGIN  = 16,
    parameter int MASK_CYCLES = 16250
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seq_en,
    input  logic              sleep_evt,
    input  logic [CODE_W-1:0] target_code,
    input  logic [CODE_W-1:0] meas_code,
    output logic              pg_ok
);
    localparam int CNT_W = $clog2(MASK_CYCLES + 1);

    pgw_state_e       state_q;
    pgw_state_e       state_d;
    logic             sleep_mask_q;
    logic             sleep_mask_d;
    logic             in_win;
    logic             sag;
    logic             restart;
    logic             t_load;
    logic             t_step;
    logic             t_done;
    logic [CNT_W-1:0] mask_cnt;

    pgw_window #(
        .CODE_W    (CODE_W),
        .LO_MARGIN (LO_MARGIN),
        .HI_MARGIN (HI_MARGIN),
        .SAG_MARGIN(SAG_MARGIN)
    ) u_window (
        .target(target_code),
        .meas  (meas_code),
        .in_win(in_win),
        .sag   (sag)
    );

    pgw_change_det #(
        .CODE_W(CODE_W)
    ) u_chg (
        .clk      (clk),
        .rst_n    (rst_n),
        .target   (target_code),
        .sleep_evt(sleep_evt),
        .restart  (restart)
    );

    pgw_mask_timer #(
        .MASK_CYCLES(MASK_CYCLES),
        .CNT_W      (CNT_W)
    ) u_timer (
        .clk  (clk),
        .rst_n(rst_n),
        .load (t_load),
        .step (t_step),
        .done (t_done),
        .cnt  (mask_cnt)
    );

    // next state and timer control
    always_comb begin
        state_d = state_q;
        t_load  = 1'b0;
        t_step  = 1'b0;
        if (!seq_en) begin
            state_d = PGW_OFF;
        end else begin
            unique case (state_q)
                PGW_OFF: begin
                    state_d = PGW_RUN;
                end
                PGW_RUN: begin
                    if (restart) begin
                        state_d = PGW_MASK;
                        t_load  = 1'b1;
                    end
                end
                PGW_MASK: begin
                    if (sleep_mask_q && sag) begin
                        state_d = PGW_SAG;
                    end else if (restart) begin
                        t_load = 1'b1;
                    end else if (t_done) begin
                        state_d = PGW_RUN;
                    end else begin
                        t_step = 1'b1;
                    end
                end
                PGW_SAG: begin
                    if (!sag) begin
                        state_d = PGW_MASK;
                        t_load  = 1'b1;
                    end
                end
                default: begin
                    state_d = PGW_OFF;
                end
            endcase
        end
    end

    // remembers that the running mask came from a sleep transition
    always_comb begin
        sleep_mask_d = sleep_mask_q;
        if ((state_d == PGW_OFF) || (state_d == PGW_RUN)) begin
            sleep_mask_d = 1'b0;
        end else if (sleep_evt) begin
            sleep_mask_d = 1'b1;
        end else if ((state_q == PGW_SAG) && (state_d == PGW_MASK)) begin
            sleep_mask_d = 1'b0;
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q      <= PGW_OFF;
            sleep_mask_q <= 1'b0;
        end else begin
            state_q      <= state_d;
            sleep_mask_q <= sleep_mask_d;
        end
    end

    // output register: live only in RUN with no restart, frozen otherwise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pg_ok <= 1'b0;
        end else if (!seq_en || (state_q == PGW_OFF)) begin
            pg_ok <= 1'b0;
        end else if ((state_q == PGW_RUN) && !restart) begin
            pg_ok <= in_win;
        end
    end

endmodule

// File: rtl/pgw_checker.sv
module pgw_checker
    import pgw_pkg::*;
#(
    parameter int CODE_W      = 8,
    parameter int HI_MARGIN   = 16,
    parameter int MASK_CYCLES = 16250,
    parameter int CNT_W       = $clog2(MASK_CYCLES + 1)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              seq_en,
    input logic [CODE_W-1:0] target_code,
    input logic [CODE_W-1:0] meas_code,
    input logic              pg_ok,
    input pgw_state_e        state_q,
    input logic              sleep_mask_q,
    input logic [CNT_W-1:0]  mask_cnt
);
    // R3
    off_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !seq_en |=> !pg_ok);

    // R4
    freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (seq_en && ((state_q == PGW_MASK) || (state_q == PGW_SAG))) |=> $stable(pg_ok));

    // R9
    rise_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pg_ok) |->
            ({1'b0, $past(meas_code)} <= ({1'b0, $past(target_code)} + (CODE_W+1)'(HI_MARGIN))));

    // R6
    cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_cnt <= CNT_W'(MASK_CYCLES - 1));

    // R8
    sag_needs_sleep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == PGW_SAG) |-> sleep_mask_q);

endmodule

bind pgw_monitor pgw_checker #(
    .CODE_W     (CODE_W),
    .HI_MARGIN  (HI_MARGIN),
    .MASK_CYCLES(MASK_CYCLES),
    .CNT_W      (CNT_W)
) u_pgw_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .seq_en      (seq_en),
    .target_code (target_code),
    .meas_code   (meas_code),
    .pg_ok       (pg_ok),
    .state_q     (state_q),
    .sleep_mask_q(sleep_mask_q),
    .mask_cnt    (mask_cnt)
);

// File: tb/test_pgw_monitor.sv
`timescale 1ns/1ps
module test_pgw_monitor;
    localparam int W = 8;
    localparam int M = 6;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         seq_en = 1'b0;
    logic         sleep_evt = 1'b0;
    logic [W-1:0] target_code = 8'd100;
    logic [W-1:0] meas_code = 8'd100;
    logic         pg_ok;

    int n_chk = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    pgw_monitor #(
        .CODE_W     (W),
        .MASK_CYCLES(M)
    ) i_pgw_monitor (
        .clk        (clk),
        .rst_n      (rst_n),
        .seq_en     (seq_en),
        .sleep_evt  (sleep_evt),
        .target_code(target_code),
        .meas_code  (meas_code),
        .pg_ok      (pg_ok)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 150000) begin
            n_fail = n_fail + 1;
            n_chk  = n_chk + 1;
            $display("FAIL watchdog got=hang exp=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic chk(input logic got, input logic exp, input string req);
        n_chk = n_chk + 1;
        if (got !== exp) begin
            n_fail = n_fail + 1;
            $display("FAIL %s t=%0d m=%0d got=%0b exp=%0b", req, target_code, meas_code, got, exp);
        end
    endtask

    function automatic logic win_exp(input int t, input int m);
        return (m <= t + 16) && ((t < 24) || (m >= t - 24));
    endfunction

    task automatic settle(input int t, input int m);
        @(negedge clk);
        target_code = W'(t);
        meas_code   = W'(m);
        repeat (M + 3) @(negedge clk);
    endtask

    // called right after driving the stimulus at a falling edge
    task automatic hold_then(input logic held, input logic after, input string req);
        repeat (M + 1) begin
            @(negedge clk);
            chk(pg_ok, held, req);
        end
        @(negedge clk);
        chk(pg_ok, after, req);
    endtask

    initial begin
        int tlist[10] = '{0, 10, 23, 24, 25, 100, 200, 239, 240, 255};

        // R3: reset and disabled
        repeat (3) @(negedge clk);
        chk(pg_ok, 1'b0, "R3 reset");
        rst_n = 1'b1;
        repeat (4) begin
            @(negedge clk);
            chk(pg_ok, 1'b0, "R3 disabled");
        end
        seq_en = 1'b1;
        @(negedge clk);
        chk(pg_ok, 1'b0, "R3 first edge");
        @(negedge clk);
        chk(pg_ok, 1'b1, "R3 second edge");

        // R1 R2 R9: full sweeps
        foreach (tlist[i]) begin
            settle(tlist[i], tlist[i]);
            for (int m = 0; m < 256; m++) begin
                meas_code = W'(m);
                @(negedge clk);
                if (tlist[i] < 24)
                    chk(pg_ok, win_exp(tlist[i], m), "R2");
                else if (tlist[i] + 16 > 255)
                    chk(pg_ok, win_exp(tlist[i], m), "R9");
                else
                    chk(pg_ok, win_exp(tlist[i], m), "R1");
            end
        end

        // R4: target change freezes high flag
        settle(100, 100);
        target_code = 8'd101;
        meas_code   = 8'd0;
        hold_then(1'b1, 1'b0, "R4");

        // R4: freeze a low flag too
        settle(100, 0);
        target_code = 8'd102;
        meas_code   = 8'd102;
        hold_then(1'b0, 1'b1, "R4 low");

        // R6: reload during mask
        settle(100, 100);
        target_code = 8'd101;
        meas_code   = 8'd0;
        repeat (3) begin
            @(negedge clk);
            chk(pg_ok, 1'b1, "R6 early");
        end
        target_code = 8'd102;
        hold_then(1'b1, 1'b0, "R6");

        // R5: sleep pulse, no sag
        settle(100, 100);
        sleep_evt = 1'b1;
        meas_code = 8'd120;
        @(negedge clk);
        sleep_evt = 1'b0;
        chk(pg_ok, 1'b1, "R5");
        repeat (M) begin
            @(negedge clk);
            chk(pg_ok, 1'b1, "R5");
        end
        @(negedge clk);
        chk(pg_ok, 1'b0, "R5 end");

        // R7: sleep pulse with long sag
        settle(100, 100);
        sleep_evt = 1'b1;
        meas_code = 8'd70;
        @(negedge clk);
        sleep_evt = 1'b0;
        chk(pg_ok, 1'b1, "R7");
        repeat (20) begin
            @(negedge clk);
            chk(pg_ok, 1'b1, "R7 sag");
        end
        meas_code = 8'd120;
        hold_then(1'b1, 1'b0, "R7 after");

        // R8: sag after target change only
        settle(100, 100);
        target_code = 8'd101;
        meas_code   = 8'd70;
        hold_then(1'b1, 1'b0, "R8");

        // R3: enable drop and re-enable
        settle(100, 100);
        chk(pg_ok, 1'b1, "R3 before drop");
        seq_en = 1'b0;
        @(negedge clk);
        chk(pg_ok, 1'b0, "R3 drop");
        seq_en = 1'b1;
        @(negedge clk);
        chk(pg_ok, 1'b0, "R3 re-enable first");
        @(negedge clk);
        chk(pg_ok, 1'b1, "R3 re-enable second");

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule